// File: doc/BRIEF.md
# Serial EEPROM Slave on a Two-Wire Bus

This block is the target side of a two-wire serial bus (I2C-compatible) placed in front of a small byte-wide data store. The store has 128 locations of 8 bits. It is modelled as a register array. A counter of system clocks stands in for the programming time of real nonvolatile cells. The clock and data lines arrive as plain inputs. The data line is open-drain: the block drives it only low, through a separate output-enable. Both lines pass through two-flop synchronisers, and all bus events are decoded on the system clock.

A master stores one byte with a byte write. It then polls the block with its device address. While the programming timer runs, the block withholds the acknowledge. One internal address counter serves three read modes. A current-address read continues from where the last access left off. A random read loads the counter with a dummy write, then reads after a repeated start. A sequential read streams bytes for as long as the master acknowledges them.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the output-enable is low, every store location holds 0x00 and the address counter is 0, so a current-address read returns 0x00.
- R2: A start is a falling data line while the clock is high. A stop is a rising data line while the clock is high. A stop in the middle of a data byte ends the transaction and stores nothing.
- R3: The block acknowledges only the address byte whose upper seven bits equal 1010 followed by the CHIP_SEL value. Bit 0 of that byte selects read (1) or write (0). Any other address is answered with no acknowledge.
- R4: A byte write sends the word address and then one data byte, and both are acknowledged. Only the low 7 bits of the word address are used. The byte is stored at the stop that ends the write.
- R5: The programming timer starts at that stop and runs for WR_CYCLES system clocks. During this time a device address is decoded but not acknowledged. After it ends, the same address is acknowledged.
- R6: The address counter advances after every byte read or written, and it wraps from 127 to 0.
- R7: A current-address read returns the location the counter points at, as the previous access left it.
- R8: A random read is a write of the word address followed by a repeated start and a read. The repeated start starts no programming cycle, so the read address is acknowledged at once. A data byte that was followed by a repeated start instead of a stop is not stored.
- R9: A sequential read sends consecutive locations while the master acknowledges each byte. A no-acknowledge leaves the data line released until the stop.
- R10: A second data byte in the same write is not acknowledged, and it is not stored.
- R11: The data line output value is always 0. Only the output-enable carries data.
- R12: The output-enable changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_out | output | 1 | Value driven on the data line when enabled (always 0) |
| sda_oe | output | 1 | Pulls the data line low when high |

## Verification
The assertions assume that the master changes the data line only while the clock is low, except for start and stop conditions. They also assume that each clock phase lasts several system clocks, so the synchronised clock edge arrives before the next phase begins. The bench drives every bit with quarter and half periods of 10 and 20 system clocks, and it moves lines only at falling system-clock edges. Its poll loop spaces device-address attempts so that the first attempt always falls inside the programming window.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CLASS = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_WIGN, ST_RDATA, ST_RACK
    } eep_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b, input logic [2:0] sel);
        return b[BYTE_W-1:1] == {DEV_CLASS, sel};
    endfunction
endpackage

// File: rtl/eep_bus_cond.sv
`timescale 1ns/1ps
module eep_bus_cond
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev,
    output logic    scl_lvl
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_in};
            sda_sync <= {sda_sync[0], sda_in};
            scl_q    <= scl_sync[1];
            sda_q    <= sda_sync[1];
        end
    end

    always_comb begin
        ev.start = scl_sync[1] & scl_q & sda_q & ~sda_sync[1];
        ev.stop  = scl_sync[1] & scl_q & ~sda_q & sda_sync[1];
        ev.rise  = scl_sync[1] & ~scl_q;
        ev.fall  = ~scl_sync[1] & scl_q;
        ev.sda   = sda_sync[1];
        scl_lvl  = scl_sync[1];
    end

    // R2
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));
endmodule

// File: rtl/eep_store.sv
`timescale 1ns/1ps
module eep_store
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int WR_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYCLES);

    logic [BYTE_W-1:0] cells [DEPTH];
    logic [CW-1:0]     timer;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            timer <= '0;
        end else if (commit) begin
            cells[wr_addr] <= wr_data;
            timer          <= WR_LOAD;
        end else if (timer != '0) begin
            timer <= timer - 1'b1;
        end
    end

    assign rd_data = cells[rd_addr];
    assign busy    = (timer != '0);

    // R5
    commit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !busy);
    // R5
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));
endmodule

// File: rtl/eeprom_i2c_slave.sv
`timescale 1ns/1ps
module eeprom_i2c_slave
    import eep_pkg::*;
#(
    parameter int         ADDR_W    = 7,
    parameter logic [2:0] CHIP_SEL  = 3'b000,
    parameter int         WR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_out,
    output logic sda_oe
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    bus_ev_t           ev;
    logic              scl_lvl;
    eep_state_t        st;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] rx, tx;
    logic              ack_arm, rd_mode, wr_pend, commit, busy;
    logic [ADDR_W-1:0] addr_cnt, wr_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    eep_bus_cond i_cond (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .ev(ev), .scl_lvl(scl_lvl)
    );

    eep_store #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) i_store (
        .clk(clk), .rst(rst), .rd_addr(addr_cnt), .rd_data(rd_data),
        .commit(commit), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            ack_arm  <= 1'b0;
            rd_mode  <= 1'b0;
            wr_pend  <= 1'b0;
            commit   <= 1'b0;
            addr_cnt <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
            sda_oe   <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (ev.start) begin
                st      <= ST_DEV;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                wr_pend <= 1'b0;
                ack_arm <= 1'b0;
            end else if (ev.stop) begin
                if (wr_pend) commit <= 1'b1;
                wr_pend <= 1'b0;
                st      <= ST_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (ev.rise) begin
                            rx     <= {rx[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 3'd7) begin
                                ack_arm <= 1'b0;
                                st <= (st == ST_DEV)   ? ST_DEV_ACK :
                                      (st == ST_WADDR) ? ST_WADDR_ACK : ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (ev.fall) begin
                            if (!ack_arm) begin
                                if (dev_match(rx, CHIP_SEL) && !busy) begin
                                    sda_oe  <= 1'b1;
                                    ack_arm <= 1'b1;
                                    rd_mode <= rx[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                ack_arm <= 1'b0;
                                bitcnt  <= '0;
                                if (rd_mode) begin
                                    sda_oe   <= ~rd_data[BYTE_W-1];
                                    tx       <= rd_data;
                                    addr_cnt <= addr_cnt + 1'b1;
                                    st       <= ST_RDATA;
                                end else begin
                                    sda_oe <= 1'b0;
                                    st     <= ST_WADDR;
                                end
                            end
                        end
                    end
                    ST_WADDR_ACK: begin
                        if (ev.fall) begin
                            if (!ack_arm) begin
                                sda_oe   <= 1'b1;
                                ack_arm  <= 1'b1;
                                addr_cnt <= rx[ADDR_W-1:0];
                            end else begin
                                sda_oe  <= 1'b0;
                                ack_arm <= 1'b0;
                                bitcnt  <= '0;
                                st      <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (ev.fall) begin
                            if (!ack_arm) begin
                                sda_oe   <= 1'b1;
                                ack_arm  <= 1'b1;
                                wr_addr  <= addr_cnt;
                                wr_data  <= rx;
                                wr_pend  <= 1'b1;
                                addr_cnt <= addr_cnt + 1'b1;
                            end else begin
                                sda_oe  <= 1'b0;
                                ack_arm <= 1'b0;
                                st      <= ST_WIGN;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RACK;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                sda_oe <= ~tx[BYTE_W-2];
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            if (ev.sda) st <= ST_IDLE;
                            else        ack_arm <= 1'b1;
                        end else if (ev.fall && ack_arm) begin
                            ack_arm  <= 1'b0;
                            bitcnt   <= '0;
                            sda_oe   <= ~rd_data[BYTE_W-1];
                            tx       <= rd_data;
                            addr_cnt <= addr_cnt + 1'b1;
                            st       <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_out = 1'b0;

    // R3
    dev_phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV) |-> !sda_oe);
    // R5
    busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEV_ACK && busy) |-> !sda_oe);
    // R12
    oe_low_clock_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl);
    // R6
    addr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WDATA_ACK && ev.fall && !ack_arm && !ev.start && !ev.stop
         && addr_cnt == LAST_ADDR) |=> (addr_cnt == '0));
    // R4
    stop_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && wr_pend) |=> commit);
endmodule

// File: tb/test_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module test_eeprom_i2c_slave;
    localparam int Q = 10;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_out, sda_oe;
    wire  sda_line = m_sda & ~sda_oe;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    eeprom_i2c_slave #(.ADDR_W(7), .CHIP_SEL(3'b000), .WR_CYCLES(1000)) i_eeprom_i2c_slave (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line),
        .sda_out(sda_out), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(Q);
            m_scl = 1'b1; wt(H);
            m_scl = 1'b0; wt(Q);
        end
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(H/2);
        ack = ~sda_line;
        wt(H/2);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            m_scl = 1'b1; wt(H/2);
            d[i] = sda_line;
            wt(H/2);
            m_scl = 1'b0; wt(Q);
        end
        m_sda = ~mack; wt(Q);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(Q);
        m_sda = 1'b1;
    endtask

    // poll with the device address until acknowledged; checks R5
    task automatic poll_ready(input string req);
        logic a;
        int   polls = 0;
        bit   ready = 0;
        bit   first_nack = 0;
        for (int k = 0; k < 8 && !ready; k++) begin
            bus_start();
            send_byte(8'hA0, a);
            bus_stop();
            polls++;
            if (k == 0) first_nack = ~a;
            ready = a;
        end
        chk(first_nack, {req, " R5 first poll inside write cycle not acked"}, 0, 1);
        chk(ready && polls <= 5, {req, " R5 ack returns after write cycle"}, polls, 3);
    endtask

    task automatic byte_write(input logic [7:0] wa, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(wa, a1);
        send_byte(d, a2);
        bus_stop();
        chk(a0 && a1 && a2, "R4 byte write acknowledged", {a0, a1, a2}, 3'b111);
        poll_ready("R4");
    endtask

    task automatic random_read(input logic [7:0] wa, input int n, output logic [7:0] got [4]);
        logic a;
        bus_start();
        send_byte(8'hA0, a);
        send_byte(wa, a);
        bus_start();
        send_byte(8'hA1, a);
        chk(a, "R8 read address acked after repeated start", a, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, got[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        logic a;
        logic [7:0] d;
        chk(sda_oe == 1'b0, "R1 output-enable low after reset", sda_oe, 0);
        chk(sda_out == 1'b0, "R11 output value low", sda_out, 0);
        bus_start();
        send_byte(8'hA1, a);
        chk(a, "R3 matching read address acked", a, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk(d == 8'h00, "R1 R7 current read after reset", d, 8'h00);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'hB0, a);
        bus_stop();
        chk(!a, "R3 wrong class address not acked", a, 0);
        bus_start();
        send_byte(8'hA2, a);
        bus_stop();
        chk(!a, "R3 wrong select bits not acked", a, 0);
    endtask

    task automatic t_write_read();
        logic [7:0] g [4];
        logic a;
        byte_write(8'h05, 8'hA5);
        byte_write(8'h06, 8'h77);
        byte_write(8'h8A, 8'h3C);
        random_read(8'h05, 1, g);
        chk(g[0] == 8'hA5, "R8 random read of 0x05", g[0], 8'hA5);
        bus_start();
        send_byte(8'hA1, a);
        recv_byte(1'b0, g[1]);
        bus_stop();
        chk(g[1] == 8'h77, "R7 R6 current read continues at 0x06", g[1], 8'h77);
        random_read(8'h0A, 1, g);
        chk(g[0] == 8'h3C, "R4 word address bit 7 ignored", g[0], 8'h3C);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] g [4];
        byte_write(8'h7F, 8'hEE);
        byte_write(8'h00, 8'h11);
        random_read(8'h7E, 4, g);
        chk(g[0] == 8'h00 && g[1] == 8'hEE, "R9 sequential read bytes 0x7E 0x7F",
            {g[0], g[1]}, 16'h00EE);
        chk(g[2] == 8'h11, "R6 counter wraps 127 to 0", g[2], 8'h11);
        chk(g[3] == 8'h00, "R9 sequential read fourth byte", g[3], 8'h00);
        chk(sda_oe == 1'b0, "R9 line released after no-ack and stop", sda_oe, 0);
    endtask

    task automatic t_rstart_drop();
        logic a;
        logic [7:0] d;
        logic [7:0] g [4];
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h20, a);
        send_byte(8'h55, a);
        bus_start();
        send_byte(8'hA1, a);
        chk(a, "R8 no write cycle after repeated start", a, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk(d == 8'h00, "R6 read continues at 0x21", d, 8'h00);
        random_read(8'h20, 1, g);
        chk(g[0] == 8'h00, "R8 byte before repeated start not stored", g[0], 8'h00);
    endtask

    task automatic t_second_byte();
        logic a0, a1, a2;
        logic [7:0] g [4];
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h30, a0);
        send_byte(8'h12, a1);
        send_byte(8'h34, a2);
        bus_stop();
        chk(a1 && !a2, "R10 second data byte not acked", {a1, a2}, 2'b10);
        poll_ready("R10");
        random_read(8'h30, 2, g);
        chk(g[0] == 8'h12 && g[1] == 8'h00, "R10 only first byte stored",
            {g[0], g[1]}, 16'h1200);
    endtask

    task automatic t_stop_abort();
        logic a;
        logic [7:0] g [4];
        bus_start();
        send_byte(8'hA0, a);
        send_byte(8'h05, a);
        for (int i = 0; i < 4; i++) begin
            m_sda = 1'b0; wt(Q);
            m_scl = 1'b1; wt(H);
            m_scl = 1'b0; wt(Q);
        end
        bus_stop();
        bus_start();
        send_byte(8'hA0, a);
        bus_stop();
        chk(a, "R2 stop mid-byte starts no write cycle", a, 1);
        random_read(8'h05, 1, g);
        chk(g[0] == 8'hA5, "R2 stop mid-byte stores nothing", g[0], 8'hA5);
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset();
        t_bad_addr();
        t_write_read();
        t_seq_wrap();
        t_rstart_drop();
        t_second_byte();
        t_stop_abort();
        chk(sda_out == 1'b0, "R11 output value stays low", sda_out, 0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog R1 actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule